// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the data side of a small 32-bit processor in which every internal transfer goes over one shared bus. It holds a register file, a program counter, an instruction register, an ALU operand register, an ALU result register, a memory address register and a memory data register. A sequencer outside the block supplies a vector of gating strobes once per clock. The block then drives the bus from the selected source, runs the ALU, and loads every register whose load strobe is high on the next rising edge.

The memory data register sits between the internal bus and the external memory bus. It has separate load and drive strobes on each side. Read and write requests to memory stay raised until the memory signals completion. The block reports a wait condition so that the sequencer can hold its current step. The block does no instruction decoding and no sequencing. It exposes the instruction word and a negative flag for use by the sequencer.

Top module: `sbDatapath`

## Requirements
- R1: After reset every general register, IR, Y, Z, MAR and MDR is zero, PC equals parameter RESET_PC, the negative flag is low and no memory request is pending.
- R2: The internal bus carries the bitwise OR of all sources whose drive strobe is high, and zero when none is high. The sources are general register i (regOutEn[i]), PC (pcOut), Z (zOut), MDR (mdrOut) and the offset field (offsetOut). busValue shows the bus in the same cycle.
- R3: busConflict is high in exactly the cycles in which two or more drive strobes are high.
- R4: General registers, PC, IR, Y and MAR load the bus value at the rising edge when their load strobe is high, and otherwise hold their value. irWord shows IR and memAddr shows MAR.
- R5: The ALU's first operand is Y, or the constant CONST_VAL when constSel is high. Its second operand is the bus. aluFunc selects the operation: 0 A+B+carryIn, 1 A-B, 2 AND, 3 OR, 4 XOR, 5 A, 6 B, 7 NOT B. Z loads the result at the edge where zIn is high.
- R6: negFlag loads bit 31 of the ALU result at the edge where zIn is high, and holds its value otherwise.
- R7: With offsetOut high, the offset source carries IR bits [OFF_W-1:0] sign-extended from bit OFF_W-1 to 32 bits.
- R8: memRead raises memReadReq from the next edge on. The request stays high until the edge of a cycle in which memDone is high, and a new memRead takes priority over that clear.
- R9: At an edge where mdrInMem and memDone are both high, MDR loads memRdData. This takes priority over a bus load through mdrIn. Otherwise mdrIn loads MDR from the bus.
- R10: memWrite raises memWriteReq under the same set and clear rules as R8. memWrData equals MDR while mdrOutMem is high and zero otherwise.
- R11: memWait is high exactly when a read or write request is pending and memDone is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regOutEn | input | NREGS | Drive strobe per general register |
| regInEn | input | NREGS | Load strobe per general register |
| pcOut | input | 1 | PC drives the bus |
| pcIn | input | 1 | PC loads from the bus |
| irIn | input | 1 | IR loads from the bus |
| offsetOut | input | 1 | Sign-extended IR offset drives the bus |
| yIn | input | 1 | Y loads from the bus |
| constSel | input | 1 | ALU first operand is the constant instead of Y |
| zIn | input | 1 | Z and negative flag load from the ALU |
| zOut | input | 1 | Z drives the bus |
| marIn | input | 1 | MAR loads from the bus |
| mdrIn | input | 1 | MDR loads from the bus |
| mdrOut | input | 1 | MDR drives the bus |
| mdrInMem | input | 1 | MDR loads from memory data when memDone |
| mdrOutMem | input | 1 | MDR drives the memory write data |
| aluFunc | input | 3 | ALU operation code |
| carryIn | input | 1 | Carry into the ALU add |
| memRead | input | 1 | Start a memory read |
| memWrite | input | 1 | Start a memory write |
| memDone | input | 1 | Memory operation complete |
| memRdData | input | 32 | Data returned by memory |
| memAddr | output | 32 | Memory address (MAR) |
| memWrData | output | 32 | Data to memory |
| memReadReq | output | 1 | Read request pending |
| memWriteReq | output | 1 | Write request pending |
| memWait | output | 1 | Request pending and not yet complete |
| busValue | output | 32 | Current internal bus value |
| busConflict | output | 1 | More than one bus driver enabled |
| irWord | output | 32 | Instruction register contents |
| negFlag | output | 1 | Sign of the last captured ALU result |

## Verification
The bus, busConflict, memWait and memWrData follow the strobes within the same cycle. The bench samples them 2 ns after it drives the strobes, well before the next rising edge. Register loads, Z, the negative flag and the request flags appear one edge later. The bench updates its model at the rising edge and compares these values in the sample point of the following cycle. Values held in registers that have no port of their own are read back by driving them onto the bus in a later step and comparing busValue.

// File: rtl/sbdp_pkg.sv
package sbdp_pkg;
  parameter int DW    = 32;
  parameter int NREGS = 4;
  parameter int NSRC  = NREGS + 4;
  parameter int SRC_PC  = NREGS;
  parameter int SRC_Z   = NREGS + 1;
  parameter int SRC_MDR = NREGS + 2;
  parameter int SRC_OFF = NREGS + 3;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_PASA = 3'd5,
    ALU_PASB = 3'd6,
    ALU_NOTB = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic [NSRC-1:0]  drive;
    logic [NREGS-1:0] regLoad;
    logic             pcLoad;
    logic             irLoad;
    logic             yLoad;
    logic             zLoad;
    logic             marLoad;
    logic             mdrBusLoad;
    logic             mdrMemLoad;
    logic             mdrDriveMem;
    logic             useConst;
    logic             carry;
    aluOp_e           aluOp;
  } strobes_t;
endpackage

// File: rtl/sbdpControl.sv
module sbdpControl
  import sbdp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NREGS-1:0] regOutEn,
  input  logic [NREGS-1:0] regInEn,
  input  logic             pcOut,
  input  logic             pcIn,
  input  logic             irIn,
  input  logic             offsetOut,
  input  logic             yIn,
  input  logic             constSel,
  input  logic             zIn,
  input  logic             zOut,
  input  logic             marIn,
  input  logic             mdrIn,
  input  logic             mdrOut,
  input  logic             mdrInMem,
  input  logic             mdrOutMem,
  input  logic [2:0]       aluFunc,
  input  logic             carryIn,
  input  logic             memRead,
  input  logic             memWrite,
  input  logic             memDone,
  output strobes_t         strobes,
  output logic             busConflict,
  output logic             memReadReq,
  output logic             memWriteReq,
  output logic             memWait
);
  localparam int CNT_W = $clog2(NSRC + 1);

  logic [NSRC-1:0] driveVec;
  logic [CNT_W-1:0] driverCount;

  assign driveVec = {offsetOut, mdrOut, zOut, pcOut, regOutEn};

  always_comb begin
    driverCount = '0;
    for (int i = 0; i < NSRC; i++) begin
      driverCount = driverCount + CNT_W'(driveVec[i]);
    end
  end

  assign busConflict = (driverCount > CNT_W'(1));

  always_comb begin
    strobes             = '0;
    strobes.drive       = driveVec;
    strobes.regLoad     = regInEn;
    strobes.pcLoad      = pcIn;
    strobes.irLoad      = irIn;
    strobes.yLoad       = yIn;
    strobes.zLoad       = zIn;
    strobes.marLoad     = marIn;
    strobes.mdrBusLoad  = mdrIn;
    strobes.mdrMemLoad  = mdrInMem & memDone;
    strobes.mdrDriveMem = mdrOutMem;
    strobes.useConst    = constSel;
    strobes.carry       = carryIn;
    strobes.aluOp       = aluOp_e'(aluFunc);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReadReq  <= 1'b0;
      memWriteReq <= 1'b0;
    end else begin
      memReadReq  <= memRead  | (memReadReq  & ~memDone);
      memWriteReq <= memWrite | (memWriteReq & ~memDone);
    end
  end

  assign memWait = (memReadReq | memWriteReq) & ~memDone;
endmodule

// File: rtl/sbdpDatapath.sv
module sbdpDatapath
  import sbdp_pkg::*;
#(
  parameter logic [DW-1:0] RESET_PC  = '0,
  parameter logic [DW-1:0] CONST_VAL = DW'(4),
  parameter int            OFF_W     = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strobes,
  input  logic [DW-1:0] memRdData,
  output logic [DW-1:0] busValue,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic [DW-1:0] irWord,
  output logic          negFlag
);
  localparam int EXT_W = DW - OFF_W;

  logic [DW-1:0] regFile [NREGS];
  logic [DW-1:0] pcReg, irReg, yReg, zReg, marReg, mdrReg;
  logic [DW-1:0] srcVal [NSRC];
  logic [DW-1:0] opA, aluOut, offsetExt;

  assign offsetExt = {{EXT_W{irReg[OFF_W-1]}}, irReg[OFF_W-1:0]};

  for (genvar g = 0; g < NREGS; g++) begin : gRegFile
    assign srcVal[g] = regFile[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   regFile[g] <= '0;
      else if (strobes.regLoad[g]) regFile[g] <= busValue;
    end
  end

  assign srcVal[SRC_PC]  = pcReg;
  assign srcVal[SRC_Z]   = zReg;
  assign srcVal[SRC_MDR] = mdrReg;
  assign srcVal[SRC_OFF] = offsetExt;

  always_comb begin
    busValue = '0;
    for (int i = 0; i < NSRC; i++) begin
      busValue = busValue | (srcVal[i] & {DW{strobes.drive[i]}});
    end
  end

  assign opA = strobes.useConst ? CONST_VAL : yReg;

  always_comb begin
    unique case (strobes.aluOp)
      ALU_ADD:  aluOut = opA + busValue + DW'(strobes.carry);
      ALU_SUB:  aluOut = opA - busValue;
      ALU_AND:  aluOut = opA & busValue;
      ALU_OR:   aluOut = opA | busValue;
      ALU_XOR:  aluOut = opA ^ busValue;
      ALU_PASA: aluOut = opA;
      ALU_PASB: aluOut = busValue;
      ALU_NOTB: aluOut = ~busValue;
      default:  aluOut = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg   <= RESET_PC;
      irReg   <= '0;
      yReg    <= '0;
      zReg    <= '0;
      marReg  <= '0;
      mdrReg  <= '0;
      negFlag <= 1'b0;
    end else begin
      if (strobes.pcLoad)  pcReg  <= busValue;
      if (strobes.irLoad)  irReg  <= busValue;
      if (strobes.yLoad)   yReg   <= busValue;
      if (strobes.marLoad) marReg <= busValue;
      if (strobes.zLoad) begin
        zReg    <= aluOut;
        negFlag <= aluOut[DW-1];
      end
      if (strobes.mdrMemLoad)      mdrReg <= memRdData;
      else if (strobes.mdrBusLoad) mdrReg <= busValue;
    end
  end

  assign memAddr   = marReg;
  assign irWord    = irReg;
  assign memWrData = strobes.mdrDriveMem ? mdrReg : '0;
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sbdp_pkg::*;
#(
  parameter logic [DW-1:0] RESET_PC  = '0,
  parameter logic [DW-1:0] CONST_VAL = DW'(4),
  parameter int            OFF_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NREGS-1:0] regOutEn,
  input  logic [NREGS-1:0] regInEn,
  input  logic             pcOut,
  input  logic             pcIn,
  input  logic             irIn,
  input  logic             offsetOut,
  input  logic             yIn,
  input  logic             constSel,
  input  logic             zIn,
  input  logic             zOut,
  input  logic             marIn,
  input  logic             mdrIn,
  input  logic             mdrOut,
  input  logic             mdrInMem,
  input  logic             mdrOutMem,
  input  logic [2:0]       aluFunc,
  input  logic             carryIn,
  input  logic             memRead,
  input  logic             memWrite,
  input  logic             memDone,
  input  logic [DW-1:0]    memRdData,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWrData,
  output logic             memReadReq,
  output logic             memWriteReq,
  output logic             memWait,
  output logic [DW-1:0]    busValue,
  output logic             busConflict,
  output logic [DW-1:0]    irWord,
  output logic             negFlag
);
  strobes_t strobes;

  sbdpControl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regOutEn(regOutEn), .regInEn(regInEn),
    .pcOut(pcOut), .pcIn(pcIn), .irIn(irIn), .offsetOut(offsetOut),
    .yIn(yIn), .constSel(constSel), .zIn(zIn), .zOut(zOut),
    .marIn(marIn), .mdrIn(mdrIn), .mdrOut(mdrOut),
    .mdrInMem(mdrInMem), .mdrOutMem(mdrOutMem),
    .aluFunc(aluFunc), .carryIn(carryIn),
    .memRead(memRead), .memWrite(memWrite), .memDone(memDone),
    .strobes(strobes), .busConflict(busConflict),
    .memReadReq(memReadReq), .memWriteReq(memWriteReq), .memWait(memWait)
  );

  sbdpDatapath #(
    .RESET_PC(RESET_PC), .CONST_VAL(CONST_VAL), .OFF_W(OFF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memRdData(memRdData),
    .busValue(busValue), .memAddr(memAddr), .memWrData(memWrData),
    .irWord(irWord), .negFlag(negFlag)
  );
endmodule

// File: rtl/sbDatapathChk.sv
module sbDatapathChk
  import sbdp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [NREGS-1:0] regOutEn,
  input logic             pcOut,
  input logic             offsetOut,
  input logic             zOut,
  input logic             mdrOut,
  input logic             marIn,
  input logic             mdrOutMem,
  input logic             memRead,
  input logic             memWrite,
  input logic             memDone,
  input logic [DW-1:0]    memAddr,
  input logic [DW-1:0]    memWrData,
  input logic             memReadReq,
  input logic             memWriteReq,
  input logic             memWait,
  input logic [DW-1:0]    busValue,
  input logic             busConflict,
  input logic [DW-1:0]    irWord
);
  logic [NSRC-1:0] drv;
  assign drv = {offsetOut, mdrOut, zOut, pcOut, regOutEn};

  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (drv == '0) |-> (busValue == '0)); // R2
  AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    busConflict == ($countones(drv) > 1)); // R3
  AST_MAR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    marIn |=> (memAddr == $past(busValue))); // R4
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !marIn |=> $stable(memAddr)); // R4
  AST_READ_SET: assert property (@(posedge clk) disable iff (!rstN)
    memRead |=> memReadReq); // R8
  AST_READ_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (memReadReq && !memDone) |=> memReadReq); // R8
  AST_WRITE_SET: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> memWriteReq); // R10
  AST_WDATA_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !mdrOutMem |-> (memWrData == '0)); // R10
  AST_WAIT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    memWait |-> (!memDone && (memReadReq || memWriteReq))); // R11
endmodule

bind sbDatapath sbDatapathChk u_chk (.*);

// File: tb/sbDatapath_tb.sv
`timescale 1ns/1ps
module sbDatapath_tb;
  import sbdp_pkg::*;

  localparam logic [31:0] RST_PC = 32'h0000_0100;
  localparam logic [31:0] KVAL   = 32'd4;
  localparam int          OFFW   = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NREGS-1:0] regOutEn, regInEn;
  logic pcOut, pcIn, irIn, offsetOut, yIn, constSel, zIn, zOut, marIn;
  logic mdrIn, mdrOut, mdrInMem, mdrOutMem, carryIn, memRead, memWrite, memDone;
  logic [2:0] aluFunc;
  logic [31:0] memRdData, memAddr, memWrData, busValue, irWord;
  logic memReadReq, memWriteReq, memWait, busConflict, negFlag;

  int checks = 0;
  int errors = 0;

  logic [31:0] mReg [NREGS];
  logic [31:0] mPc, mIr, mY, mZ, mMar, mMdr;
  logic mN, mRd, mWr;

  always #10 clk = ~clk;

  sbDatapath #(.RESET_PC(RST_PC), .CONST_VAL(KVAL), .OFF_W(OFFW)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expBus();
    logic [31:0] b = '0;
    for (int i = 0; i < NREGS; i++) if (regOutEn[i]) b |= mReg[i];
    if (pcOut) b |= mPc;
    if (zOut) b |= mZ;
    if (mdrOut) b |= mMdr;
    if (offsetOut) b |= {{(32-OFFW){mIr[OFFW-1]}}, mIr[OFFW-1:0]};
    return b;
  endfunction

  function automatic logic [31:0] expAlu(logic [31:0] b);
    logic [31:0] a = constSel ? KVAL : mY;
    case (aluFunc)
      3'd0: return a + b + {31'd0, carryIn};
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a;
      3'd6: return b;
      default: return ~b;
    endcase
  endfunction

  task automatic clearIns();
    regOutEn = '0; regInEn = '0;
    {pcOut, pcIn, irIn, offsetOut, yIn, constSel, zIn, zOut, marIn} = '0;
    {mdrIn, mdrOut, mdrInMem, mdrOutMem, carryIn, memRead, memWrite, memDone} = '0;
    aluFunc = 3'd0; memRdData = '0;
  endtask

  // Called with inputs driven after a falling edge; compares, then advances the model.
  task automatic cycle();
    logic [31:0] b, r;
    int cnt;
    #2;
    b = expBus();
    cnt = $countones({offsetOut, mdrOut, zOut, pcOut, regOutEn});
    chk("R2 bus", busValue, b);
    chk("R3 conflict", {31'd0, busConflict}, {31'd0, cnt > 1});
    chk("R4 ir", irWord, mIr);
    chk("R4 mar", memAddr, mMar);
    chk("R6 neg", {31'd0, negFlag}, {31'd0, mN});
    chk("R8 rdreq", {31'd0, memReadReq}, {31'd0, mRd});
    chk("R10 wrreq", {31'd0, memWriteReq}, {31'd0, mWr});
    chk("R10 wdata", memWrData, mdrOutMem ? mMdr : 32'd0);
    chk("R11 wait", {31'd0, memWait}, {31'd0, (mRd | mWr) & ~memDone});
    r = expAlu(b);
    @(posedge clk);
    for (int i = 0; i < NREGS; i++) if (regInEn[i]) mReg[i] = b;
    if (pcIn) mPc = b;
    if (irIn) mIr = b;
    if (yIn) mY = b;
    if (marIn) mMar = b;
    if (zIn) begin mZ = r; mN = r[31]; end
    if (mdrInMem && memDone) mMdr = memRdData;
    else if (mdrIn) mMdr = b;
    mRd = memRead | (mRd & ~memDone);
    mWr = memWrite | (mWr & ~memDone);
    @(negedge clk);
  endtask

  task automatic setDriver(int s);
    case (s)
      NREGS: pcOut = 1'b1;
      NREGS + 1: zOut = 1'b1;
      NREGS + 2: mdrOut = 1'b1;
      NREGS + 3: offsetOut = 1'b1;
      default: regOutEn[s] = 1'b1;
    endcase
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clearIns();
    for (int i = 0; i < NREGS; i++) mReg[i] = '0;
    mPc = RST_PC; mIr = '0; mY = '0; mZ = '0; mMar = '0; mMdr = '0;
    mN = 1'b0; mRd = 1'b0; mWr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    #1;
    chk("R1 bus idle", busValue, 32'd0);
    chk("R1 mar", memAddr, 32'd0);
    chk("R1 ir", irWord, 32'd0);
    chk("R1 flags", {29'd0, negFlag, memReadReq, memWriteReq}, 32'd0);
    pcOut = 1'b1; #1;
    chk("R1 pc", busValue, RST_PC);
    cycle(); clearIns();

    // R8/R9: read with a delayed completion
    pcOut = 1'b1; marIn = 1'b1; memRead = 1'b1; cycle(); clearIns();
    chk("R8 address", memAddr, RST_PC);
    mdrInMem = 1'b1; mdrIn = 1'b1; pcOut = 1'b1; #1;
    chk("R8 wait", {31'd0, memWait}, 32'd1);
    cycle(); clearIns();
    mdrInMem = 1'b1; mdrIn = 1'b1; pcOut = 1'b1; memDone = 1'b1;
    memRdData = 32'h0000_0F00; cycle(); clearIns();
    mdrOut = 1'b1; #1;
    chk("R9 mem over bus", busValue, 32'h0000_0F00);
    irIn = 1'b1; cycle(); clearIns();

    // R7: negative offset sign extension
    offsetOut = 1'b1; #1;
    chk("R7 offset", busValue, 32'hFFFF_FF00);
    yIn = 1'b1; cycle(); clearIns();

    // R5: carry add and constant select
    pcOut = 1'b1; zIn = 1'b1; aluFunc = 3'd0; carryIn = 1'b1; cycle(); clearIns();
    zOut = 1'b1; #1;
    chk("R5 Y+B+1", busValue, 32'hFFFF_FF00 + RST_PC + 32'd1);
    cycle(); clearIns();
    pcOut = 1'b1; constSel = 1'b1; zIn = 1'b1; aluFunc = 3'd1; cycle(); clearIns();
    zOut = 1'b1; #1;
    chk("R5 const-B", busValue, KVAL - RST_PC);
    chk("R6 negative", {31'd0, negFlag}, 32'd1);
    cycle(); clearIns();

    // R10: write sequence
    pcOut = 1'b1; mdrIn = 1'b1; memWrite = 1'b1; cycle(); clearIns();
    mdrOutMem = 1'b1; #1;
    chk("R10 write data", memWrData, RST_PC);
    cycle(); clearIns();

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int sel;
      clearIns();
      sel = $urandom_range(0, 9);
      if (sel >= 2) setDriver($urandom_range(0, NSRC - 1));
      if (sel == 2) setDriver($urandom_range(0, NSRC - 1));
      regInEn = NREGS'($urandom) & NREGS'($urandom);
      pcIn = ($urandom_range(0, 9) == 0);
      irIn = ($urandom_range(0, 5) == 0);
      yIn = $urandom_range(0, 2) == 0;
      zIn = $urandom_range(0, 2) == 0;
      marIn = $urandom_range(0, 3) == 0;
      mdrIn = $urandom_range(0, 3) == 0;
      mdrInMem = $urandom_range(0, 2) == 0;
      mdrOutMem = $urandom_range(0, 1) == 0;
      constSel = $urandom_range(0, 3) == 0;
      carryIn = $urandom_range(0, 1) == 0;
      aluFunc = 3'($urandom);
      memRead = $urandom_range(0, 9) == 0;
      memWrite = $urandom_range(0, 9) == 0;
      memDone = $urandom_range(0, 2) == 0;
      memRdData = $urandom;
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule